// File: doc/BRIEF.md
# Valley-Lockout Turn-On Selector

This block decides when the power switch of a quasi-resonant flyback controller is switched on again. A digitised feedback level in millivolts sets how deep into the ringing the next turn-on may happen. High feedback selects the first valley. Lower feedback selects the second, third or fourth valley. Below the lowest band the block enters a frequency-foldback (VCO) mode and stops issuing valley turn-ons. The thresholds for falling feedback differ from those for rising feedback, so a chosen valley stays locked while the load wanders inside its band.

Each gate-off event starts a new switching cycle. At that point the valley choice is re-evaluated from the current feedback level. Valley pulses from the zero-crossing comparator are ignored for a fixed blanking window. After the window, valley pulses are counted. When the count reaches the selected valley number, the block issues a one-cycle turn-on request. If the ringing is too damped to produce a valley, a timeout acts as a substitute valley. The timeout is stretched while soft-start is active.

Top module: `vls_turn_on_sel`

## Requirements
- R1: After reset, `valley_sel` is 1, `vco_mode` is 0 and `turn_on` is 0. `valley_sel` carries 1, 2, 3 or 4 for the selected valley and 0 for VCO mode. `vco_mode` is high exactly when `valley_sel` is 0.
- R2: When a gate-off is sampled, the selection moves deeper while the feedback is strictly below the falling threshold of the current position: 1400 mV (1 to 2), 1200 mV (2 to 3), 900 mV (3 to 4), 800 mV (4 to VCO). Several steps may be taken in one update.
- R3: When a gate-off is sampled, the selection moves shallower while the feedback is strictly above the rising threshold of the current position: 1400 mV (VCO to 4), 1600 mV (4 to 3), 1800 mV (3 to 2), 2000 mV (2 to 1). Several steps may be taken in one update.
- R4: The selection changes only on a clock edge that samples `gate_off` high. Feedback between a position's two thresholds leaves it unchanged. Feedback changes without a gate-off have no effect.
- R5: Valley pulses sampled on the BLANK_CYC edges that follow the gate-off edge are not counted.
- R6: After blanking, each counted event advances the valley count, which starts at zero. On the edge whose event brings the count to `valley_sel`, `turn_on` goes high for exactly one cycle. No further request follows until the next gate-off.
- R7: If TMO_CYC edges pass after blanking ends, or after the previous counted event, with no valley pulse, a substitute event is counted on the last of those edges.
- R8: While `soft_start` is high, the substitute-event window is TMO_SS_CYC edges instead of TMO_CYC.
- R9: A valley pulse on the same edge as a substitute event advances the count by exactly one.
- R10: In VCO mode the block never raises `turn_on`.
- R11: A gate-off during counting clears the valley count and restarts blanking.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_mv | input | FB_W | Feedback level in millivolts |
| valley_pulse | input | 1 | One-cycle pulse per detected valley |
| gate_off | input | 1 | One-cycle pulse at the end of the on-time |
| soft_start | input | 1 | High while soft-start is active |
| turn_on | output | 1 | One-cycle turn-on request |
| vco_mode | output | 1 | High when VCO mode is selected |
| valley_sel | output | 3 | Selected valley, 1 to 4; 0 means VCO mode |

## Verification
A real valley pulse and the expiry of the substitute-valley timeout can land on the same clock edge. The design must then count a single event. The bench provokes this by placing a valley pulse exactly on the edge where the first timeout of a third-valley cycle expires. It then checks that the turn-on request appears only after two further timeouts, not one. Random runs also let the two coincide freely, and a cycle-level reference model compares the request timing on every cycle.

// File: rtl/vls_pkg.sv
package vls_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_BLANK = 2'd1,
    PH_COUNT = 2'd2
  } vls_phase_e;

  localparam int unsigned DEPTH_W   = 3;
  localparam int unsigned DEPTH_VCO = 4;

  // depth 0..3 -> valley 1..4, depth 4 -> code 0 (VCO)
  function automatic logic [DEPTH_W-1:0] depth_to_code(input logic [DEPTH_W-1:0] d);
    if (d >= DEPTH_W'(DEPTH_VCO)) return '0;
    return d + DEPTH_W'(1);
  endfunction

endpackage

// File: rtl/vls_zone_sel.sv
module vls_zone_sel
  import vls_pkg::*;
#(
  parameter int FB_W    = 12,
  parameter int DN_1TO2 = 1400,
  parameter int DN_2TO3 = 1200,
  parameter int DN_3TO4 = 900,
  parameter int DN_4TOV = 800,
  parameter int UP_VTO4 = 1400,
  parameter int UP_4TO3 = 1600,
  parameter int UP_3TO2 = 1800,
  parameter int UP_2TO1 = 2000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd,
  input  logic [FB_W-1:0]    fb,
  output logic [DEPTH_W-1:0] depth
);

  localparam int STAGES = DEPTH_VCO;

  logic [DEPTH_W-1:0] depth_q;
  logic [DEPTH_W-1:0] depth_d;
  logic [DEPTH_W-1:0] walk;
  logic               depth_en;

  function automatic logic [FB_W-1:0] fall_th(input logic [DEPTH_W-1:0] d);
    case (d)
      3'd0:    fall_th = FB_W'(DN_1TO2);
      3'd1:    fall_th = FB_W'(DN_2TO3);
      3'd2:    fall_th = FB_W'(DN_3TO4);
      3'd3:    fall_th = FB_W'(DN_4TOV);
      default: fall_th = '0;
    endcase
  endfunction

  function automatic logic [FB_W-1:0] rise_th(input logic [DEPTH_W-1:0] d);
    case (d)
      3'd1:    rise_th = FB_W'(UP_2TO1);
      3'd2:    rise_th = FB_W'(UP_3TO2);
      3'd3:    rise_th = FB_W'(UP_4TO3);
      3'd4:    rise_th = FB_W'(UP_VTO4);
      default: rise_th = '1;
    endcase
  endfunction

  // settle the hysteresis walk; thresholds guarantee monotonic motion
  always_comb begin
    walk = depth_q;
    for (int s = 0; s < STAGES; s++) begin
      if ((walk < DEPTH_W'(DEPTH_VCO)) && (fb < fall_th(walk))) begin
        walk = walk + DEPTH_W'(1);
      end else if ((walk != '0) && (fb > rise_th(walk))) begin
        walk = walk - DEPTH_W'(1);
      end
    end
  end

  assign depth_en = upd;
  assign depth_d  = walk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
    end else if (depth_en) begin
      depth_q <= depth_d;
    end
  end

  assign depth = depth_q;

endmodule

// File: rtl/vls_win_timer.sv
module vls_win_timer
  import vls_pkg::*;
#(
  parameter int BLANK_CYC  = 315,
  parameter int TMO_CYC    = 550,
  parameter int TMO_SS_CYC = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  vls_phase_e phase,
  input  logic       restart,
  input  logic       soft_start,
  output logic       done
);

  localparam int LIM_A   = (BLANK_CYC > TMO_CYC) ? BLANK_CYC : TMO_CYC;
  localparam int LIM_MAX = (LIM_A > TMO_SS_CYC) ? LIM_A : TMO_SS_CYC;
  localparam int CW      = $clog2(LIM_MAX + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] lim;
  logic          cnt_en;

  always_comb begin
    case (phase)
      PH_BLANK: lim = CW'(BLANK_CYC - 1);
      PH_COUNT: lim = soft_start ? CW'(TMO_SS_CYC - 1) : CW'(TMO_CYC - 1);
      default:  lim = '0;
    endcase
  end

  // >= keeps the window closing when soft-start drops mid-count
  assign done = (phase != PH_IDLE) && (cnt_q >= lim);

  always_comb begin
    cnt_en = restart || (phase != PH_IDLE);
    if (restart || done || (phase == PH_IDLE)) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/vls_valley_cnt.sv
module vls_valley_cnt
  import vls_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               inc,
  input  logic [DEPTH_W-1:0] sel_code,
  output logic               hit
);

  logic [DEPTH_W-1:0] cnt_q;
  logic [DEPTH_W-1:0] cnt_d;
  logic               cnt_en;

  always_comb begin
    cnt_en = clr || inc;
    cnt_d  = clr ? '0 : cnt_q + DEPTH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // the pending event is the one that completes the selected count
  assign hit = ((cnt_q + DEPTH_W'(1)) == sel_code);

endmodule

// File: rtl/vls_phase_ctl.sv
module vls_phase_ctl
  import vls_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gate_off,
  input  logic       valley_pulse,
  input  logic       win_done,
  input  logic       sel_vco,
  input  logic       hit,
  output vls_phase_e phase,
  output logic       evt,
  output logic       fire,
  output logic       turn_on
);

  vls_phase_e phase_q;
  vls_phase_e phase_d;
  logic       turn_on_q;

  assign evt  = (phase_q == PH_COUNT) && !gate_off && (valley_pulse || win_done);
  assign fire = evt && hit;

  always_comb begin
    phase_d = phase_q;
    if (gate_off) begin
      phase_d = PH_BLANK;
    end else begin
      case (phase_q)
        PH_BLANK: if (win_done) phase_d = sel_vco ? PH_IDLE : PH_COUNT;
        PH_COUNT: if (fire)     phase_d = PH_IDLE;
        default:                phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      turn_on_q <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      turn_on_q <= fire;
    end
  end

  assign phase   = phase_q;
  assign turn_on = turn_on_q;

endmodule

// File: rtl/vls_turn_on_sel.sv
module vls_turn_on_sel
  import vls_pkg::*;
#(
  parameter int FB_W       = 12,
  parameter int BLANK_CYC  = 315,
  parameter int TMO_CYC    = 550,
  parameter int TMO_SS_CYC = 4000,
  parameter int DN_1TO2    = 1400,
  parameter int DN_2TO3    = 1200,
  parameter int DN_3TO4    = 900,
  parameter int DN_4TOV    = 800,
  parameter int UP_VTO4    = 1400,
  parameter int UP_4TO3    = 1600,
  parameter int UP_3TO2    = 1800,
  parameter int UP_2TO1    = 2000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FB_W-1:0] fb_mv,
  input  logic            valley_pulse,
  input  logic            gate_off,
  input  logic            soft_start,
  output logic            turn_on,
  output logic            vco_mode,
  output logic [2:0]      valley_sel
);

  logic [DEPTH_W-1:0] depth;
  logic [DEPTH_W-1:0] sel_code;
  logic               sel_vco;
  logic               win_done;
  logic               evt;
  logic               fire;
  logic               hit;
  vls_phase_e         phase;

  vls_zone_sel #(
    .FB_W(FB_W),
    .DN_1TO2(DN_1TO2), .DN_2TO3(DN_2TO3), .DN_3TO4(DN_3TO4), .DN_4TOV(DN_4TOV),
    .UP_VTO4(UP_VTO4), .UP_4TO3(UP_4TO3), .UP_3TO2(UP_3TO2), .UP_2TO1(UP_2TO1)
  ) u_zone (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (gate_off),
    .fb    (fb_mv),
    .depth (depth)
  );

  assign sel_code = depth_to_code(depth);
  assign sel_vco  = (depth == DEPTH_W'(DEPTH_VCO));

  vls_win_timer #(
    .BLANK_CYC(BLANK_CYC), .TMO_CYC(TMO_CYC), .TMO_SS_CYC(TMO_SS_CYC)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .restart    (gate_off || evt),
    .soft_start (soft_start),
    .done       (win_done)
  );

  vls_valley_cnt u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (gate_off || fire),
    .inc      (evt),
    .sel_code (sel_code),
    .hit      (hit)
  );

  vls_phase_ctl u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .gate_off     (gate_off),
    .valley_pulse (valley_pulse),
    .win_done     (win_done),
    .sel_vco      (sel_vco),
    .hit          (hit),
    .phase        (phase),
    .evt          (evt),
    .fire         (fire),
    .turn_on      (turn_on)
  );

  assign vco_mode   = sel_vco;
  assign valley_sel = sel_code;

endmodule

// File: rtl/vls_turn_on_sel_chk.sv
module vls_turn_on_sel_chk #(
  parameter int FB_W      = 12,
  parameter int BLANK_CYC = 315,
  parameter int DN_4TOV   = 800,
  parameter int UP_2TO1   = 2000
) (
  input logic            clk,
  input logic            rst_n,
  input logic [FB_W-1:0] fb_mv,
  input logic            gate_off,
  input logic            turn_on,
  input logic            vco_mode,
  input logic [2:0]      valley_sel
);

  localparam int SW = $clog2(BLANK_CYC + 2) + 1;

  logic [SW-1:0] since_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_off <= '0;
    end else if (gate_off) begin
      since_off <= '0;
    end else if (since_off <= SW'(BLANK_CYC)) begin
      since_off <= since_off + SW'(1);
    end
  end

  a_r1_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    valley_sel <= 3'd4);

  a_r2_deep_low: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_off && (fb_mv < FB_W'(DN_4TOV))) |=> vco_mode);

  a_r3_top_high: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_off && (fb_mv > FB_W'(UP_2TO1))) |=> (valley_sel == 3'd1));

  a_r4_hold_sel: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_off |=> $stable(valley_sel));

  a_r5_blank_gap: assert property (@(posedge clk) disable iff (!rst_n)
    turn_on |-> (since_off > SW'(BLANK_CYC)));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    turn_on |=> !turn_on);

  a_r10_vco_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    vco_mode |-> !turn_on);

endmodule

bind vls_turn_on_sel vls_turn_on_sel_chk #(
  .FB_W(FB_W), .BLANK_CYC(BLANK_CYC), .DN_4TOV(DN_4TOV), .UP_2TO1(UP_2TO1)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fb_mv      (fb_mv),
  .gate_off   (gate_off),
  .turn_on    (turn_on),
  .vco_mode   (vco_mode),
  .valley_sel (valley_sel)
);

// File: tb/vls_turn_on_sel_test.sv
module vls_turn_on_sel_test;

  localparam int CLK_PERIOD = 10;
  localparam int FB_W   = 12;
  localparam int BLK    = 20;
  localparam int TMO    = 40;
  localparam int TMO_SS = 150;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [FB_W-1:0] fb_mv = '0;
  logic            valley_pulse = 1'b0;
  logic            gate_off = 1'b0;
  logic            soft_start = 1'b0;
  logic            turn_on;
  logic            vco_mode;
  logic [2:0]      valley_sel;

  int    total = 0;
  int    bad = 0;
  bit    finished = 1'b0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  vls_turn_on_sel #(
    .FB_W(FB_W), .BLANK_CYC(BLK), .TMO_CYC(TMO), .TMO_SS_CYC(TMO_SS)
  ) uut (
    .clk(clk), .rst_n(rst_n), .fb_mv(fb_mv), .valley_pulse(valley_pulse),
    .gate_off(gate_off), .soft_start(soft_start), .turn_on(turn_on),
    .vco_mode(vco_mode), .valley_sel(valley_sel)
  );

  // ---------------- reference model ----------------
  int m_sel;  // 1..4 valley, 0 VCO
  int m_ph;   // 0 idle, 1 blank, 2 count
  int m_t;
  int m_cnt;
  bit m_on;

  function automatic int next_sel(int cur, int fb);
    int s = cur;
    for (int k = 0; k < 4; k++) begin
      int dn;
      int up;
      case (s)
        1:       begin dn = 1400; up = 1 << 20; end
        2:       begin dn = 1200; up = 2000;    end
        3:       begin dn = 900;  up = 1800;    end
        4:       begin dn = 800;  up = 1600;    end
        default: begin dn = -1;   up = 1400;    end
      endcase
      if (fb < dn)      s = (s == 4) ? 0 : s + 1;
      else if (fb > up) s = (s == 0) ? 4 : s - 1;
    end
    return s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = 1; m_ph = 0; m_t = 0; m_cnt = 0; m_on = 1'b0;
    end else begin
      m_on = 1'b0;
      if (gate_off) begin
        m_sel = next_sel(m_sel, int'(fb_mv));
        m_ph = 1; m_t = 0; m_cnt = 0;
      end else if (m_ph == 1) begin
        if (m_t >= BLK - 1) begin
          m_ph = (m_sel == 0) ? 0 : 2;
          m_t = 0;
        end else begin
          m_t++;
        end
      end else if (m_ph == 2) begin
        int lim;
        bit ev;
        lim = soft_start ? TMO_SS : TMO;
        ev  = valley_pulse || (m_t >= lim - 1);
        if (ev) begin
          m_t = 0;
          m_cnt++;
          if (m_cnt == m_sel) begin
            m_on = 1'b1; m_cnt = 0; m_ph = 0;
          end
        end else begin
          m_t++;
        end
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit vp, input bit go, input bit ss, input int fb);
    @(negedge clk);
    chk({cur_req, " turn_on vs model"}, int'(turn_on), int'(m_on));
    chk({cur_req, " valley_sel vs model"}, int'(valley_sel), m_sel);
    chk({cur_req, " vco_mode vs model"}, int'(vco_mode), int'(m_sel == 0));
    valley_pulse = vp; gate_off = go; soft_start = ss; fb_mv = FB_W'(fb);
  endtask

  task automatic set_sel(input string req, input int fb, input int exp);
    cur_req = req;
    cyc(1'b0, 1'b1, 1'b0, fb);
    cyc(1'b0, 1'b0, 1'b0, fb);
    chk({req, " selection"}, int'(valley_sel), exp);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R6 watchdog actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int seed_ret;
    int thr[7];
    int fb_cur;
    seed_ret = $urandom(32'h1357);
    thr = '{800, 900, 1200, 1400, 1600, 1800, 2000};

    repeat (3) @(negedge clk);
    chk("R1 reset valley_sel", int'(valley_sel), 1);
    chk("R1 reset turn_on", int'(turn_on), 0);
    chk("R1 reset vco_mode", int'(vco_mode), 0);
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 2500);
    chk("R1 after release valley_sel", int'(valley_sel), 1);

    // thresholds, falling then rising, with exact boundaries
    set_sel("R2", 1400, 1);
    set_sel("R2", 1399, 2);
    set_sel("R2", 1200, 2);
    set_sel("R2", 1199, 3);
    set_sel("R2", 899, 4);
    set_sel("R2", 800, 4);
    set_sel("R2", 799, 0);
    set_sel("R3", 1400, 0);
    set_sel("R3", 1401, 4);
    set_sel("R3", 1601, 3);
    set_sel("R3", 1800, 3);
    set_sel("R3", 1801, 2);
    set_sel("R3", 2000, 2);
    set_sel("R3", 2001, 1);
    set_sel("R2", 500, 0);
    set_sel("R3", 3000, 1);
    set_sel("R4", 1500, 1);
    set_sel("R4", 1399, 2);
    set_sel("R4", 1500, 2);

    // R4: feedback swings without gate-off leave the selection alone
    cur_req = "R4";
    for (int i = 0; i < 30; i++) cyc(1'b0, 1'b0, 1'b0, (i % 2) ? 100 : 3000);
    chk("R4 no gate-off selection", int'(valley_sel), 2);

    // R5/R6: second valley, pulses inside blanking ignored
    cur_req = "R5";
    cyc(1'b0, 1'b1, 1'b0, 1300);
    for (int i = 1; i <= BLK; i++) cyc((i == 1) || (i == BLK), 1'b0, 1'b0, 1300);
    chk("R5 no request after blanked pulses", int'(turn_on), 0);
    cur_req = "R6";
    cyc(1'b1, 1'b0, 1'b0, 1300);
    cyc(1'b0, 1'b0, 1'b0, 1300);
    cyc(1'b1, 1'b0, 1'b0, 1300);
    cyc(1'b0, 1'b0, 1'b0, 1300);
    chk("R6 request on second valley", int'(turn_on), 1);
    cyc(1'b0, 1'b0, 1'b0, 1300);
    chk("R6 request lasts one cycle", int'(turn_on), 0);
    for (int i = 0; i < 3 * TMO; i++) cyc(1'b1, 1'b0, 1'b0, 1300);
    chk("R6 nothing more until gate-off", int'(turn_on), 0);

    // R7: third valley by timeouts only
    set_sel("R7", 1000, 3);
    cyc(1'b0, 1'b1, 1'b0, 1000);
    for (int j = 1; j <= BLK + 3 * TMO + 3; j++) begin
      cyc(1'b0, 1'b0, 1'b0, 1000);
      chk("R7 timeout request timing", int'(turn_on), int'(j == BLK + 3 * TMO + 1));
    end

    // R8: soft-start stretches the window
    cur_req = "R8";
    cyc(1'b0, 1'b1, 1'b1, 1000);
    for (int j = 1; j <= BLK + 3 * TMO_SS + 3; j++) begin
      cyc(1'b0, 1'b0, 1'b1, 1000);
      chk("R8 soft-start request timing", int'(turn_on), int'(j == BLK + 3 * TMO_SS + 1));
    end

    // R9: valley coincides with first timeout, counted once
    cur_req = "R9";
    cyc(1'b0, 1'b1, 1'b0, 1000);
    for (int j = 1; j <= BLK + 3 * TMO + 3; j++) begin
      cyc(j == BLK + TMO, 1'b0, 1'b0, 1000);
      chk("R9 coincident event counted once", int'(turn_on), int'(j == BLK + 3 * TMO + 1));
    end

    // R10: VCO issues nothing
    set_sel("R10", 500, 0);
    cyc(1'b0, 1'b1, 1'b0, 500);
    for (int j = 0; j < 300; j++) begin
      cyc((j % 3) == 0, 1'b0, 1'b0, 500);
      chk("R10 no request in VCO", int'(turn_on), 0);
    end

    // R11: gate-off mid-count clears the count
    set_sel("R11", 2500, 1);
    set_sel("R11", 1300, 2);
    for (int i = 1; i <= BLK; i++) cyc(1'b0, 1'b0, 1'b0, 1300);
    cyc(1'b1, 1'b0, 1'b0, 1300);
    cyc(1'b0, 1'b1, 1'b0, 1300);
    for (int i = 1; i <= BLK; i++) cyc(1'b0, 1'b0, 1'b0, 1300);
    cyc(1'b1, 1'b0, 1'b0, 1300);
    cyc(1'b0, 1'b0, 1'b0, 1300);
    chk("R11 count restarted, no early request", int'(turn_on), 0);
    cyc(1'b1, 1'b0, 1'b0, 1300);
    cyc(1'b0, 1'b0, 1'b0, 1300);
    chk("R11 request after two fresh valleys", int'(turn_on), 1);

    // random mix against the model
    cur_req = "R6 random";
    fb_cur = 1500;
    for (int n = 0; n < 8000; n++) begin
      bit go;
      bit vp;
      bit ss;
      go = ($urandom_range(0, 119) == 0);
      vp = ($urandom_range(0, 14) == 0);
      ss = ((n / 2000) % 2) == 1;
      if (go) begin
        if ($urandom_range(0, 1) == 0) fb_cur = thr[$urandom_range(0, 6)] + $urandom_range(0, 2) - 1;
        else                           fb_cur = $urandom_range(0, 2600);
      end else if ($urandom_range(0, 9) == 0) begin
        fb_cur = $urandom_range(0, 2600);
      end
      cyc(vp, go, ss, fb_cur);
    end
    cyc(1'b0, 1'b0, 1'b0, fb_cur);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule